// File: doc/BRIEF.md
# Multi-Level Wavelet Filter Slot Scheduler

This block is the control unit of a separable two-dimensional wavelet engine that keeps up to three resolution levels running on one shared horizontal filter and one shared pair of vertical filters. It tracks the raster position (column, row) of an N x N frame. For every accepted pixel it decides whether the horizontal filter works this cycle, and for which level, and does the same for the vertical filters. Work for a coarser level is placed in columns that the finer levels leave empty, so the levels never compete for a filter.

Each level's slots follow a closed-form column pattern with a stride of 2, 4 or 8, and a row pattern that depends on how many rows of that level are already buffered. When the last slot of a level in a row lands past the row end, it is moved to a fixed early column of the next row. A frame starts on a frame-start pulse and the block goes idle once the last pixel of the frame has been accepted.

Top module: `dwt_level_sched`

## Requirements
- R1: After reset, `busy` is 0, `col` and `row` are 0, and `h_en` and `v_en` are 0.
- R2: A cycle with `frame_start` high issues no operation (`h_en` and `v_en` are 0) and leaves `busy` at 1 with `col` and `row` at 0 on the next cycle.
- R3: While `busy` is 1 and `frame_start` is 0, a cycle with `step` high advances the position in raster order (column first, then row). A cycle with `step` low keeps the position and issues no operation.
- R4: Horizontal level 1 is issued at every odd column of every row.
- R5: Horizontal level 2 is issued on odd rows at columns 6, 10, 14 and so on (column mod 4 = 2, column at least 6). Its wrapped slot is column 2 of each even row from row 2 on.
- R6: Horizontal level 3 is issued on rows with row mod 4 = 3 at columns 12, 20 and so on (column mod 8 = 4, column at least 12). Its wrapped slot is column 4 of rows with row mod 4 = 0 from row 4 on.
- R7: Vertical level 1 is issued on odd rows at every even column from 2 on. Its wrapped slot is column 0 of each even row from row 2 on.
- R8: Vertical level 2 is issued on rows with row mod 4 = 3 at columns 7, 11 and so on (column mod 4 = 3, column at least 7). Its wrapped slot is column 3 of rows with row mod 4 = 0 from row 4 on.
- R9: Vertical level 3 is issued on rows with row mod 8 = 7 at columns 13, 21 and so on (column mod 8 = 5, column at least 13). Its wrapped slot is column 5 of rows with row mod 8 = 0 from row 8 on.
- R10: The level fields `h_lvl` and `v_lvl` carry 1, 2 or 3 for the issuing level and 0 when the matching enable is low. At most one level claims each filter type in any cycle.
- R11: Accepting the pixel at column N-1, row N-1 drops `busy` and returns the position to 0,0. No operation is then issued until the next `frame_start`, so slots that the last row would wrap are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Begin a new frame at position 0,0 |
| step | input | 1 | A pixel is accepted at the current position this cycle |
| busy | output | 1 | A frame is in progress |
| col | output | log2(N) | Current raster column |
| row | output | log2(N) | Current raster row |
| h_en | output | 1 | Horizontal filter operation issued this cycle |
| h_lvl | output | 2 | Level of the horizontal operation (0 when idle) |
| v_en | output | 1 | Vertical filter operation issued this cycle |
| v_lvl | output | 2 | Level of the vertical operation (0 when idle) |

## Verification
The properties assume that `frame_start` and `step` are clean, synchronous single-bit controls, and that N is a power of two of at least 16, so that every level has at least one slot in each eligible row. They also assume that `step` may stall at any point without changing the schedule. The stimulus drives both controls at the falling edge only. It stalls `step` and pulses `frame_start` both inside a frame and after its end, which exercises the hold, restart and end-of-frame properties without ever breaking these assumptions.

// File: rtl/dwt_sched_pkg.sv
// Package: shared level type and per-level slot offsets for the scheduler.
// Assumes at most three levels; offsets are the first column of each pattern.
package dwt_sched_pkg;

    localparam int MAX_LEVELS = 3;

    typedef logic [1:0] lvl_t;

    // First horizontal slot column of a level.
    function automatic int h_first_col(input int lvl);
        case (lvl)
            1:       return 1;
            2:       return 6;
            default: return 12;
        endcase
    endfunction

    // First vertical slot column of a level.
    function automatic int v_first_col(input int lvl);
        case (lvl)
            1:       return 2;
            2:       return 7;
            default: return 13;
        endcase
    endfunction

endpackage

// File: rtl/sched_raster_counter.sv
// Module: raster position counter for one N x N frame.
// Assumes N is a power of two. frame_start wins over step; the frame ends
// after the pixel at (N-1, N-1) is accepted and the counter then idles.
module sched_raster_counter #(
    parameter int N  = 16,
    localparam int XW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          step,
    output logic [XW-1:0] col,
    output logic [XW-1:0] row,
    output logic          busy,
    output logic          issue
);

    localparam logic [XW-1:0] LAST_IDX = XW'(N - 1);

    // A slot may be used only while a frame runs and a pixel is accepted.
    always_comb begin
        issue = busy && step && !frame_start;
    end

    // Advance the raster position, restart on frame_start, stop at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col  <= '0;
            row  <= '0;
            busy <= 1'b0;
        end else if (frame_start) begin
            col  <= '0;
            row  <= '0;
            busy <= 1'b1;
        end else if (issue) begin
            if (col == LAST_IDX) begin
                col <= '0;
                if (row == LAST_IDX) begin
                    row  <= '0;
                    busy <= 1'b0;
                end else begin
                    row <= row + 1'b1;
                end
            end else begin
                col <= col + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sched_slot_decoder.sv
// Module: decides whether one level owns one filter type at (col, row).
// The in-row slots are FIRST + STRIDE*k on eligible rows. A last slot that
// falls at or past column N is moved to column (last - N) of the row after an
// eligible row. Row 0 never takes a wrapped slot. Assumes N >= 16, power of 2.
module sched_slot_decoder
    import dwt_sched_pkg::*;
#(
    parameter int N       = 16,
    parameter int LVL     = 1,
    parameter bit IS_VERT = 1'b0,
    localparam int XW = $clog2(N)
) (
    input  logic [XW-1:0] col,
    input  logic [XW-1:0] row,
    output logic          hit
);

    localparam int STRIDE   = 1 << LVL;
    localparam int FIRST    = IS_VERT ? v_first_col(LVL) : h_first_col(LVL);
    localparam int ROW_MOD  = IS_VERT ? STRIDE : STRIDE / 2;
    localparam int LAST     = FIRST + STRIDE * (N / STRIDE - 1);
    localparam bit HAS_WRAP = (LAST >= N);
    localparam int WRAP_COL = HAS_WRAP ? (LAST - N) : 0;

    localparam logic [XW-1:0] FIRST_C  = XW'(FIRST);
    localparam logic [XW-1:0] STR_MASK = XW'(STRIDE - 1);
    localparam logic [XW-1:0] ROW_MASK = XW'(ROW_MOD - 1);
    localparam logic [XW-1:0] WRAP_C   = XW'(WRAP_COL);

    logic          row_eligible;
    logic          row_after;
    logic          in_row_hit;
    logic          wrap_hit;
    logic [XW-1:0] col_rel;

    // Classify the row: eligible for in-row slots, or right after such a row.
    always_comb begin
        row_eligible = ((row & ROW_MASK) == ROW_MASK);
        row_after    = (row != '0) && ((row & ROW_MASK) == '0);
    end

    // Match the stride pattern from the first slot column.
    always_comb begin
        col_rel    = col - FIRST_C;
        in_row_hit = row_eligible && (col >= FIRST_C) && ((col_rel & STR_MASK) == '0);
    end

    // Match the wrapped slot carried over from the previous row.
    always_comb begin
        wrap_hit = HAS_WRAP && row_after && (col == WRAP_C);
        hit      = in_row_hit || wrap_hit;
    end

endmodule

// File: rtl/sched_level_merge.sv
// Module: folds per-level hits of one filter type into an enable and a level
// number (1-based, 0 when idle). Hits are disjoint by schedule; if they were
// not, the lowest level would win. Gated by the issue qualifier.
module sched_level_merge
    import dwt_sched_pkg::*;
#(
    parameter int LEVELS = 3
) (
    input  logic [LEVELS-1:0] hits,
    input  logic              issue,
    output logic              en,
    output lvl_t              lvl
);

    // Pick the level that owns the slot, scanning from the coarsest down.
    always_comb begin
        en  = 1'b0;
        lvl = '0;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (issue && hits[i]) begin
                en  = 1'b1;
                lvl = lvl_t'(i + 1);
            end
        end
    end

endmodule

// File: rtl/dwt_level_sched.sv
// Module: top of the multi-level wavelet filter slot scheduler.
// Counts the raster position and, per accepted pixel, issues at most one
// horizontal and one vertical operation tagged with its level (1..LEVELS).
// Assumes N is a power of two, N >= 16, and 1 <= LEVELS <= 3.
module dwt_level_sched
    import dwt_sched_pkg::*;
#(
    parameter int N      = 16,
    parameter int LEVELS = 3,
    localparam int XW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          step,
    output logic          busy,
    output logic [XW-1:0] col,
    output logic [XW-1:0] row,
    output logic          h_en,
    output lvl_t          h_lvl,
    output logic          v_en,
    output lvl_t          v_lvl
);

    logic              issue;
    logic [LEVELS-1:0] h_hit;
    logic [LEVELS-1:0] v_hit;

    sched_raster_counter #(.N(N)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .step        (step),
        .col         (col),
        .row         (row),
        .busy        (busy),
        .issue       (issue)
    );

    // One horizontal and one vertical slot decoder per enabled level.
    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        sched_slot_decoder #(.N(N), .LVL(g + 1), .IS_VERT(1'b0)) u_hdec (
            .col (col),
            .row (row),
            .hit (h_hit[g])
        );
        sched_slot_decoder #(.N(N), .LVL(g + 1), .IS_VERT(1'b1)) u_vdec (
            .col (col),
            .row (row),
            .hit (v_hit[g])
        );
    end

    sched_level_merge #(.LEVELS(LEVELS)) u_hmerge (
        .hits  (h_hit),
        .issue (issue),
        .en    (h_en),
        .lvl   (h_lvl)
    );

    sched_level_merge #(.LEVELS(LEVELS)) u_vmerge (
        .hits  (v_hit),
        .issue (issue),
        .en    (v_en),
        .lvl   (v_lvl)
    );

endmodule

// File: rtl/dwt_level_sched_chk.sv
// Checker: temporal properties of the scheduler, bound to every instance.
module dwt_level_sched_chk #(
    parameter int N      = 16,
    parameter int LEVELS = 3,
    localparam int XW = $clog2(N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              step,
    input logic              busy,
    input logic [XW-1:0]     col,
    input logic [XW-1:0]     row,
    input logic              h_en,
    input logic [1:0]        h_lvl,
    input logic              v_en,
    input logic [1:0]        v_lvl,
    input logic [LEVELS-1:0] h_hit,
    input logic [LEVELS-1:0] v_hit
);

    localparam logic [XW-1:0] LAST_IDX = XW'(N - 1);

    p_single_hlevel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(h_hit));

    p_single_vlevel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(v_hit));

    p_idle_level_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_en |-> h_lvl == 2'd0) and (!v_en |-> v_lvl == 2'd0));

    p_start_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !h_en && !v_en);

    p_start_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> busy && col == '0 && row == '0);

    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !step && !frame_start |=> $stable(col) && $stable(row) && busy);

    p_stall_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !step |-> !h_en && !v_en);

    p_col_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && step && !frame_start && col != LAST_IDX |=> col == $past(col) + 1'b1);

    p_frame_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && step && !frame_start && col == LAST_IDX && row == LAST_IDX |=> !busy);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !h_en && !v_en);

    p_row0_no_vert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        row == '0 |-> !v_en);

endmodule

bind dwt_level_sched dwt_level_sched_chk #(.N(N), .LEVELS(LEVELS)) u_chk (.*);

// File: tb/dwt_level_sched_tb.sv
// Bench: spot vectors from a table, a full-frame sweep against a closed-form
// model, then directed reset, stall, restart and frame-end tests.
module dwt_level_sched_tb;

    localparam int N  = 16;
    localparam int XW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          step = 1'b0;
    logic          busy;
    logic [XW-1:0] col;
    logic [XW-1:0] row;
    logic          h_en;
    logic [1:0]    h_lvl;
    logic          v_en;
    logic [1:0]    v_lvl;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    dwt_level_sched #(.N(N), .LEVELS(3)) u_dut (.*);

    // Spot vectors: column, row, expected horizontal level, expected vertical level.
    localparam int NV = 15;
    localparam int VEC [NV][4] = '{
        '{ 1, 0, 1, 0},   // R4
        '{ 2, 0, 0, 0},   // R5 no wrap in row 0
        '{ 6, 1, 2, 1},   // R5 R7
        '{ 2, 2, 2, 0},   // R5 wrap
        '{ 0, 2, 0, 1},   // R7 wrap
        '{12, 3, 3, 1},   // R6
        '{ 4, 4, 3, 0},   // R6 wrap
        '{ 3, 4, 1, 2},   // R8 wrap
        '{ 7, 3, 1, 2},   // R8
        '{13, 7, 1, 3},   // R9
        '{ 5, 8, 1, 3},   // R9 wrap
        '{ 5, 0, 1, 0},   // R9 no wrap in row 0
        '{ 3, 0, 1, 0},   // R8 no wrap in row 0
        '{ 2, 1, 0, 1},   // R5 below first column
        '{10,15, 2, 1}    // R5 R7 last row
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Independent model: level owning a slot at (x, y), 0 if none.
    function automatic int model_lvl(input bit vert, input int x, input int y);
        for (int lv = 1; lv <= 3; lv++) begin
            int s   = 1 << lv;
            int off = vert ? (lv == 1 ? 2 : lv == 2 ? 7 : 13)
                           : (lv == 1 ? 1 : lv == 2 ? 6 : 12);
            int rm  = vert ? s : s / 2;
            for (int k = 0; k < N / s; k++) begin
                int c = off + s * k;
                if (c < N) begin
                    if (x == c && (y % rm) == rm - 1) return lv;
                end else begin
                    if (x == c - N && y > 0 && (y % rm) == 0) return lv;
                end
            end
        end
        return 0;
    endfunction

    task automatic start_frame();
        @(negedge clk);
        frame_start = 1'b1;
        step        = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic run_steps(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step = 1'b1;
        end
        @(negedge clk);
        step = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        #1;
        check("R1 busy", busy, 0);
        check("R1 col", col, 0);
        check("R1 row", row, 0);
        check("R1 h_en", h_en, 0);
        check("R1 v_en", v_en, 0);
        rst_n = 1'b1;

        // Spot vectors from the table.
        for (int i = 0; i < NV; i++) begin
            start_frame();
            run_steps(VEC[i][1] * N + VEC[i][0]);
            step = 1'b1;
            #1;
            check("R10 spot h_lvl", h_lvl, VEC[i][2]);
            check("R10 spot v_lvl", v_lvl, VEC[i][3]);
            check("R10 spot h_en", h_en, VEC[i][2] != 0);
            check("R10 spot v_en", v_en, VEC[i][3] != 0);
        end

        // Full frame sweep against the model (R4..R9).
        start_frame();
        for (int y = 0; y < N; y++) begin
            for (int x = 0; x < N; x++) begin
                step = 1'b1;
                #1;
                check("R3 col", col, x);
                check("R3 row", row, y);
                check("R4-6 h_lvl R4", h_lvl, model_lvl(1'b0, x, y));
                check("R7-9 v_lvl R7", v_lvl, model_lvl(1'b1, x, y));
                @(negedge clk);
            end
        end
        // R11: frame ended, nothing issued even with step high.
        step = 1'b1;
        #1;
        check("R11 busy", busy, 0);
        check("R11 col", col, 0);
        check("R11 row", row, 0);
        check("R11 v_en", v_en, 0);
        check("R11 h_en", h_en, 0);
        @(negedge clk);
        step = 1'b0;

        // R3: stall keeps position and issues nothing.
        start_frame();
        run_steps(N + 6);
        #1;
        check("R3 stall h_en", h_en, 0);
        check("R3 stall v_en", v_en, 0);
        repeat (3) @(negedge clk);
        check("R3 hold col", col, 6);
        check("R3 hold row", row, 1);
        step = 1'b1;
        #1;
        check("R3 resume h_lvl", h_lvl, 2);

        // R2: frame_start mid-frame issues nothing and returns to origin.
        @(negedge clk);
        frame_start = 1'b1;
        step        = 1'b1;
        #1;
        check("R2 start h_en", h_en, 0);
        check("R2 start v_en", v_en, 0);
        @(negedge clk);
        frame_start = 1'b0;
        step        = 1'b0;
        #1;
        check("R2 busy", busy, 1);
        check("R2 col", col, 0);
        check("R2 row", row, 0);

        // R1: reset mid-frame clears state.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 busy after reset", busy, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule